// File: doc/BRIEF.md
# Multi-mode UART bit-timing generator

This block turns a fixed input clock into the per-bit timing of a UART frame of ten bits: a start bit, eight data bits and a stop bit. A small write-only register port holds the timing setup. That setup is a 16-bit clock divisor, a speed mode, a programmable per-bit tick count, a programmable sample point and a ten-position stretch mask. The divisor first produces a tick at the divided rate. A tick counter inside each bit then turns those ticks into a strobe that marks the sampling point of the bit and a strobe that marks the end of the bit.

Three oversampling schemes are available: 16 ticks per bit, 4 ticks per bit, or a programmable count of up to 256 ticks per bit. In the programmable scheme, each frame bit whose mask bit is set lasts one extra tick. This spreads a fractional part of a tick across the frame. A frame-start input aligns the prescaler, the tick counter and the bit index. The idle output rises when the last bit of the frame ends. Data shifting, buffering and interrupts belong to the blocks around this one.

Top module: `uart_bit_timer`

## Requirements
- R1: After reset, idle is 1, both strobes are 0 and bit_idx is 0. The divisor is 1, the speed mode is 0, the tick count is 15, the sample point is 7 and the stretch mask is 0.
- R2: In speed mode 0, every bit lasts 16·D clock cycles, where D is the effective divisor. sample_stb pulses 8·D cycles after the bit begins, which is the end of tick 7.
- R3: In speed mode 2, every bit lasts 4·D cycles, and sample_stb pulses 2·D cycles after the bit begins.
- R4: In speed mode 3, a bit lasts (C+1)·D cycles, where C is the tick-count register at address 4. sample_stb pulses (P+1)·D cycles after the bit begins, where P is the sample-point register at address 5. If P is not below the bit's tick count, that bit has no sample strobe.
- R5: Speed-mode values 1, 4, 5, 6 and 7 (bits 2:0 of the byte written to address 3) give exactly the timing of mode 0.
- R6: The divisor low byte is at address 0 and the high byte is at address 1. A write to either address takes effect only while bit 7 of the line-control register (address 2) is 1. Otherwise the write is ignored and the timing is unchanged.
- R7: A divisor of 0 is treated as 1.
- R8: The stretch mask is split over two addresses. Address 6 bits 7:0 cover frame bits 7:0, and address 7 bits 1:0 cover frame bits 9:8. In mode 3, a frame bit whose mask bit is 1 lasts (C+2)·D cycles.
- R9: In modes 0 and 2, the stretch mask has no effect on any timing.
- R10: frame_start clears the prescaler, the tick counter and the bit index and drops idle, even in the middle of a frame. The first bit is then timed from the cycle in which frame_start was sampled.
- R11: During a frame, bit_idx shows the current bit, 0 to 9. bit_stb pulses for one cycle at the end of each bit, and bit_idx advances with it. idle rises with the tenth bit_stb, bit_idx returns to 0, and no strobe follows until the next frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| frame_start | input | 1 | Begin a new frame (restarts all counters) |
| sample_stb | output | 1 | One-cycle pulse at the sampling point of a bit |
| bit_stb | output | 1 | One-cycle pulse at the end of each bit |
| bit_idx | output | 4 | Index of the current frame bit |
| idle | output | 1 | High when no frame is in progress |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor, an 8-bit tick count and a 10-bit frame. With those defaults, the extremes can be reached directly. A tick count of 255 gives 256 ticks per bit, and a divisor written only through the high byte gives 256 input cycles per tick. Small random divisors (0 to 4) keep frames short, so many full frames of every mode fit in the run. In each frame, the cycle of every bit strobe and sample strobe is compared with the cycle predicted from the divisor, the tick count and the stretch mask.

// File: rtl/uart_bt_pkg.sv
`timescale 1ns/1ps
package uart_bt_pkg;

    localparam int DIV_W      = 16;
    localparam int CNT_W      = 8;
    localparam int FRAME_BITS = 10;

    localparam logic [2:0] MODE_X16  = 3'd0;
    localparam logic [2:0] MODE_X4   = 3'd2;
    localparam logic [2:0] MODE_PROG = 3'd3;

    localparam int LEN_X16 = 16;
    localparam int LEN_X4  = 4;
    localparam int SP_X16  = 7;
    localparam int SP_X4   = 1;

    typedef struct packed {
        logic [DIV_W-1:0]      divisor;
        logic [2:0]            mode;
        logic [CNT_W-1:0]      samp_cnt;
        logic [CNT_W-1:0]      samp_pt;
        logic [FRAME_BITS-1:0] stretch;
    } bt_cfg_t;

endpackage

// File: rtl/bt_regs.sv
`timescale 1ns/1ps
module bt_regs
    import uart_bt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output bt_cfg_t           cfg
);

    typedef struct packed {
        logic    latch_open;
        bt_cfg_t cfg;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                3'd0: if (r_q.latch_open) r_d.cfg.divisor[7:0]  = wr_data;
                3'd1: if (r_q.latch_open) r_d.cfg.divisor[15:8] = wr_data;
                3'd2: r_d.latch_open    = wr_data[7];
                3'd3: r_d.cfg.mode      = wr_data[2:0];
                3'd4: r_d.cfg.samp_cnt  = wr_data;
                3'd5: r_d.cfg.samp_pt   = wr_data;
                3'd6: r_d.cfg.stretch[7:0] = wr_data;
                default: r_d.cfg.stretch[FRAME_BITS-1:8] = wr_data[FRAME_BITS-9:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.latch_open   <= 1'b0;
            r_q.cfg.divisor  <= DIV_W'(1);
            r_q.cfg.mode     <= MODE_X16;
            r_q.cfg.samp_cnt <= CNT_W'(LEN_X16 - 1);
            r_q.cfg.samp_pt  <= CNT_W'(SP_X16);
            r_q.cfg.stretch  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg = r_q.cfg;

    // R6: divisor bytes are guarded by the latch-access bit
    a_r6_div_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 3'd0 || wr_addr == 3'd1) && !r_q.latch_open)
            |=> $stable(r_q.cfg.divisor));

endmodule

// File: rtl/bt_prescale.sv
`timescale 1ns/1ps
module bt_prescale
    import uart_bt_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] divisor,
    output logic         tick
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t p_d, p_q;
    logic [W-1:0] div_eff;

    always_comb begin
        div_eff = (divisor == '0) ? W'(1) : divisor;
        tick    = run && !restart && (p_q.cnt >= div_eff - W'(1));
        p_d     = p_q;
        if (restart)
            p_d.cnt = '0;
        else if (run)
            p_d.cnt = tick ? '0 : p_q.cnt + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R10: a restart always leaves the prescaler at zero
    a_r10_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (p_q.cnt == '0));

    // R7: after a tick the prescaler starts its next period from zero
    a_r7_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (p_q.cnt == '0));

endmodule

// File: rtl/bt_frame.sv
`timescale 1ns/1ps
module bt_frame
    import uart_bt_pkg::*;
#(
    parameter int CW     = CNT_W,
    parameter int NBITS  = FRAME_BITS,
    parameter int IDX_W  = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             tick,
    input  logic [2:0]       mode,
    input  logic [CW-1:0]    samp_cnt,
    input  logic [CW-1:0]    samp_pt,
    input  logic [NBITS-1:0] stretch,
    output logic             busy,
    output logic             bit_stb,
    output logic             sample_stb,
    output logic [IDX_W-1:0] bit_idx
);

    localparam int TK_W = CW + 1;

    typedef struct packed {
        logic             busy;
        logic [TK_W-1:0]  tk;
        logic [IDX_W-1:0] idx;
        logic             bit_stb;
        logic             smp_stb;
    } frm_t;

    frm_t f_d, f_q;
    logic [TK_W-1:0] last_tk;
    logic [TK_W-1:0] samp_tk;
    logic            stretch_bit;

    always_comb begin
        stretch_bit = (f_q.idx < IDX_W'(NBITS)) ? stretch[f_q.idx] : 1'b0;
        case (mode)
            MODE_X4: begin
                last_tk = TK_W'(LEN_X4 - 1);
                samp_tk = TK_W'(SP_X4);
            end
            MODE_PROG: begin
                last_tk = {1'b0, samp_cnt} + {{CW{1'b0}}, stretch_bit};
                samp_tk = {1'b0, samp_pt};
            end
            default: begin
                last_tk = TK_W'(LEN_X16 - 1);
                samp_tk = TK_W'(SP_X16);
            end
        endcase

        f_d         = f_q;
        f_d.bit_stb = 1'b0;
        f_d.smp_stb = 1'b0;
        if (frame_start) begin
            f_d.busy = 1'b1;
            f_d.tk   = '0;
            f_d.idx  = '0;
        end else if (f_q.busy && tick) begin
            f_d.smp_stb = (f_q.tk == samp_tk);
            if (f_q.tk >= last_tk) begin
                f_d.tk      = '0;
                f_d.bit_stb = 1'b1;
                if (f_q.idx >= IDX_W'(NBITS - 1)) begin
                    f_d.busy = 1'b0;
                    f_d.idx  = '0;
                end else begin
                    f_d.idx = f_q.idx + IDX_W'(1);
                end
            end else begin
                f_d.tk = f_q.tk + TK_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign busy       = f_q.busy;
    assign bit_stb    = f_q.bit_stb;
    assign sample_stb = f_q.smp_stb;
    assign bit_idx    = f_q.idx;

    // R11: the bit index never leaves the frame
    a_r11_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.idx < IDX_W'(NBITS));

    // R11: strobes only follow a prescaler tick
    a_r11_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.bit_stb |-> $past(tick));
    a_r4_smp_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.smp_stb |-> $past(tick));

    // R11: inside a frame every bit strobe advances the index by one
    a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.bit_stb && f_q.busy) |-> (f_q.idx == $past(f_q.idx) + IDX_W'(1)));

    // R11: no strobes while the generator stays idle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_q.busy && !$past(f_q.busy)) |-> (!f_q.bit_stb && !f_q.smp_stb));

    // R10: frame start restarts the frame with clean outputs
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (f_q.busy && f_q.idx == '0 && !f_q.bit_stb && !f_q.smp_stb));

endmodule

// File: rtl/uart_bit_timer.sv
`timescale 1ns/1ps
module uart_bit_timer
    import uart_bt_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_start,
    output logic              sample_stb,
    output logic              bit_stb,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              idle
);

    bt_cfg_t cfg;
    logic    tick;
    logic    busy;

    bt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    bt_prescale #(.W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .restart (frame_start),
        .divisor (cfg.divisor),
        .tick    (tick)
    );

    bt_frame #(.CW(CNT_W), .NBITS(FRAME_BITS), .IDX_W(IDX_W)) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .tick        (tick),
        .mode        (cfg.mode),
        .samp_cnt    (cfg.samp_cnt),
        .samp_pt     (cfg.samp_pt),
        .stretch     (cfg.stretch),
        .busy        (busy),
        .bit_stb     (bit_stb),
        .sample_stb  (sample_stb),
        .bit_idx     (bit_idx)
    );

    assign idle = !busy;

endmodule

// File: tb/sim_uart_bit_timer.sv
`timescale 1ns/1ps
module sim_uart_bit_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       frame_start = 1'b0;
    logic       sample_stb, bit_stb, idle;
    logic [3:0] bit_idx;

    int checks = 0;
    int failures = 0;

    int b_div  = 1;
    int b_mode = 0;
    int b_sc   = 15;
    int b_sp   = 7;
    int b_mask = 0;

    always #10 clk = ~clk;

    uart_bit_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start), .sample_stb(sample_stb),
        .bit_stb(bit_stb), .bit_idx(bit_idx), .idle(idle)
    );

    function automatic int eff_div();
        return (b_div == 0) ? 1 : b_div;
    endfunction

    function automatic int bit_len(input int n);
        if (b_mode == 3) return b_sc + 1 + ((b_mask >> n) & 1);
        if (b_mode == 2) return 4;
        return 16;
    endfunction

    function automatic int samp_pt();
        if (b_mode == 3) return b_sp;
        if (b_mode == 2) return 1;
        return 7;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(input int d);
        wr(2, 8'h83);
        wr(0, d & 8'hFF);
        wr(1, (d >> 8) & 8'hFF);
        wr(2, 8'h03);
        b_div = d;
    endtask

    task automatic setup(input int d, input int m, input int sc, input int sp, input int mask);
        set_div(d);
        wr(3, m); b_mode = m & 7;
        wr(4, sc); b_sc = sc;
        wr(5, sp); b_sp = sp;
        wr(6, mask & 8'hFF);
        wr(7, (mask >> 8) & 3); b_mask = mask & 10'h3FF;
    endtask

    task automatic run_frame(input string tag);
        int ends [10];
        int smps [10];
        int start = 0;
        int d = eff_div();
        bit bad = 1'b0;
        for (int n = 0; n < 10; n++) begin
            int len = bit_len(n);
            smps[n] = (samp_pt() < len) ? start + (samp_pt() + 1) * d : -1;
            start += len * d;
            ends[n] = start;
        end
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        for (int t = 0; t <= start + 5; t++) begin
            int nend = 0;
            bit eb = 1'b0;
            bit es = 1'b0;
            int eidx;
            if (t > 0) @(negedge clk);
            for (int n = 0; n < 10; n++) begin
                if (ends[n] <= t) nend++;
                if (ends[n] == t) eb = 1'b1;
                if (smps[n] == t) es = 1'b1;
            end
            eidx = (nend == 10) ? 0 : nend;
            if (!bad && (bit_stb != eb || sample_stb != es ||
                         int'(bit_idx) != eidx || idle != (nend == 10))) begin
                bad = 1'b1;
                $display("FAIL %s t=%0d got stb=%b smp=%b idx=%0d idle=%b expected stb=%b smp=%b idx=%0d idle=%b",
                         tag, t, bit_stb, sample_stb, bit_idx, idle, eb, es, eidx, (nend == 10));
            end
        end
        checks++;
        if (bad) failures++;
    endtask

    initial begin
        #(20 * 190000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", int'(idle), 1);
        check("R1 bit_stb after reset", int'(bit_stb), 0);
        check("R1 sample_stb after reset", int'(sample_stb), 0);
        check("R1 bit_idx after reset", int'(bit_idx), 0);
        run_frame("R1 default config frame");

        setup(3, 0, 0, 0, 10'h3FF);
        run_frame("R2 mode0 div3 mask ignored R9");
        setup(5, 2, 9, 2, 10'h2AA);
        run_frame("R3 mode2 div5 mask ignored R9");
        setup(2, 1, 9, 2, 10'h155);
        run_frame("R5 mode1 as mode0");
        setup(1, 6, 3, 1, 0);
        run_frame("R5 mode6 as mode0");
        setup(0, 0, 3, 1, 0);
        run_frame("R7 divisor zero mode0");
        setup(0, 3, 4, 1, 10'h00F);
        run_frame("R7 divisor zero mode3");
        setup(1, 3, 255, 127, 0);
        run_frame("R4 mode3 count 255");
        setup(2, 3, 9, 4, 10'h055);
        run_frame("R8 mask 0x55/0");
        setup(1, 3, 7, 3, 10'h3FF);
        run_frame("R8 mask 0xFF/3");
        setup(1, 3, 5, 5, 10'h300);
        run_frame("R8 high mask only, R4 point on last tick");
        setup(1, 3, 3, 9, 0);
        run_frame("R4 sample point beyond bit");
        setup(256, 2, 3, 1, 0);
        run_frame("R6 high divisor byte");

        setup(3, 3, 6, 2, 0);
        wr(2, 8'h03);
        wr(0, 8'h09);
        wr(1, 8'h01);
        run_frame("R6 divisor writes ignored with latch bit clear");

        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 busy mid-frame", int'(idle), 0);
        run_frame("R10 restart mid-frame");

        for (int i = 0; i < 25; i++) begin
            int m  = $urandom_range(0, 7);
            int d  = $urandom_range(0, 4);
            int sc = $urandom_range(1, 40);
            int sp = $urandom_range(0, sc + 2);
            int mk = $urandom_range(0, 1023);
            setup(d, m, sc, sp, mk);
            if ((m & 7) == 3)      run_frame("R4 R8 R11 random mode3");
            else if ((m & 7) == 2) run_frame("R3 R9 R11 random mode2");
            else                   run_frame("R2 R5 R11 random mode0-like");
        end

        repeat (5) @(negedge clk);
        check("R11 stays idle after frame", int'(idle), 1);
        check("R11 no strobe after frame", int'(bit_stb | sample_stb), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule